// File: doc/BRIEF.md
# Real-Time Seconds Clock with Strobed Peripheral-Bus Access

The block keeps time in whole seconds. A prescaler running on a 32.768 kHz slow clock divides that clock down to one-cycle second ticks. Each tick advances a seconds counter.

Software reaches the block over a strobe-timed peripheral bus clocked by a faster bus clock. It can read the counter, load a new counter value, program a match value, set two interrupt enables and clear two sticky event flags. One flag records that the counter reached the match value. The other records each second tick. The single interrupt line is high while either flag is set together with its enable.

The two clock domains exchange data in two ways. A counter load goes from the bus side to the slow side through a four-phase request/acknowledge handshake, and the load data is held stable for the whole exchange. The counter goes the other way: each counter change toggles a publish bit, and the bus side synchronises that bit. The bus side copies the counter only after it has seen the toggle, and by then the slow-side value has been stable for at least two bus cycles, so a read never returns a torn value.

The load handshake is driven by a three-state machine on the bus side:
- LD_IDLE: no load is in progress. The transition "counter write" takes the machine to LD_REQ.
- LD_REQ: the request is asserted. The transition "acknowledge seen" takes the machine to LD_RELEASE.
- LD_RELEASE: the request is dropped. The transition "acknowledge gone" takes the machine back to LD_IDLE.

Top module: `rtc_pbus`

## Requirements
- R1: After reset, the counter, match, control and status registers all read zero, and `rtc_irq` is low.
- R2: The counter advances by exactly one every 2^PRESC_W slow-clock cycles. It wraps from all ones to zero.
- R3: `pb_rd_oe` is high, and `pb_rdata` carries register data, only while `pb_sel`, `pb_strobe` are high and `pb_write` is low. At all other times `pb_rdata` is zero.
- R4: Word offsets are decoded from `pb_addr`: 0 is the counter, 1 is match, 2 is control, 3 is status. Offsets 4 to 7 read zero and ignore writes. A write with `pb_sel` low changes nothing. A write takes effect once, on the first bus-clock edge of its strobe.
- R5: A write to offset 0 loads the counter through the handshake and restarts the prescaler. Once the handshake completes, reads return the loaded value, and counting continues upward from it.
- R6: Status bit 0 (match flag) sets when an update of the counter, whether by tick or by load, makes it equal to the match register.
- R7: Status bit 1 (second flag) sets on each counter increment made by a tick. A counter load does not set it.
- R8: Writing a 1 to a status bit clears that flag. Writing a 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: `rtc_irq` equals (status bit 0 AND control bit 0) OR (status bit 1 AND control bit 1). The flags stay set whatever the state of the enables.
- R10: A write to offset 0 while an earlier load is still in its handshake is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| slow_clk | input | 1 | 32.768 kHz timebase clock |
| pb_sel | input | 1 | Block select |
| pb_strobe | input | 1 | Transfer strobe |
| pb_write | input | 1 | High for write, low for read |
| pb_addr | input | 3 | Word offset |
| pb_wdata | input | 32 | Write data |
| pb_rdata | output | 32 | Read data, zero when not reading |
| pb_rd_oe | output | 1 | High while the block drives read data |
| rtc_irq | output | 1 | Interrupt, active high |

## Verification
The assertions assume three things about the inputs. The bus clock is several times faster than the slow clock. Address, direction and write data are stable for as long as the strobe is high. Reset is released cleanly in both domains. The stimulus keeps within these limits: the bus runs at 50 MHz against a slow clock with a 160 ns period, every bus field changes only on a falling bus-clock edge before the strobe rises, and a small prescaler width makes a second last 64 bus cycles. Interrupt enables are swept over all four combinations, and the expected line level is computed from the flags read back through the status register.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        LD_IDLE    = 2'd0,
        LD_REQ     = 2'd1,
        LD_RELEASE = 2'd2
    } ld_state_t;

    localparam logic [2:0] OFS_COUNT = 3'd0;
    localparam logic [2:0] OFS_MATCH = 3'd1;
    localparam logic [2:0] OFS_CTRL  = 3'd2;
    localparam logic [2:0] OFS_STAT  = 3'd3;

    localparam int BIT_MATCH = 0;
    localparam int BIT_SEC   = 1;
    localparam int NUM_EVT   = 2;

endpackage

// File: rtl/rtc_sync.sv
module rtc_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core #(
    parameter int PRESC_W = 15,
    parameter int CNT_W   = 32
) (
    input  logic             slow_clk,
    input  logic             rst_n,
    input  logic             ld_req,
    input  logic [CNT_W-1:0] ld_data,
    output logic             ld_ack,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_by_tick,
    output logic             pub_tog
);
    localparam logic [PRESC_W-1:0] PMAX = {PRESC_W{1'b1}};

    logic             req_s;
    logic [PRESC_W-1:0] presc;
    logic             do_load;

    rtc_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(slow_clk), .rst_n(rst_n), .d(ld_req), .q(req_s)
    );

    assign do_load = req_s && !ld_ack;

    always_ff @(posedge slow_clk or negedge rst_n) begin
        if (!rst_n) begin
            presc       <= '0;
            cnt         <= '0;
            ld_ack      <= 1'b0;
            cnt_by_tick <= 1'b0;
            pub_tog     <= 1'b0;
        end else begin
            ld_ack <= req_s;
            if (do_load) begin
                cnt         <= ld_data;
                presc       <= '0;
                cnt_by_tick <= 1'b0;
                pub_tog     <= ~pub_tog;
            end else if (presc == PMAX) begin
                cnt         <= cnt + 1'b1;
                presc       <= '0;
                cnt_by_tick <= 1'b1;
                pub_tog     <= ~pub_tog;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

    // R2: a full prescaler period with no load advances the count by one
    a_r2_step_one: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (presc == PMAX && !do_load) |=> (cnt == $past(cnt) + 1'b1));

    // R5: a load places the held data and restarts the prescaler
    a_r5_load_applies: assert property (@(posedge slow_clk) disable iff (!rst_n)
        do_load |=> (cnt == $past(ld_data) && presc == '0));
endmodule

// File: rtl/rtc_bus_regs.sv
module rtc_bus_regs
    import rtc_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             strobe,
    input  logic             write,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             rd_oe,
    output logic             irq,
    output logic             ld_req,
    output logic [CNT_W-1:0] ld_data,
    input  logic             ld_ack_s,
    input  logic             pub_s,
    input  logic [CNT_W-1:0] cnt_slow,
    input  logic             tick_slow
);
    ld_state_t state_q, state_d;

    logic               strobe_q, pub_d, evt;
    logic               wr_go, wr_cnt, wr_stat;
    logic [CNT_W-1:0]   cnt_q, match_q;
    logic [NUM_EVT-1:0] en_q, flag_q, flag_set;

    assign wr_go   = sel && strobe && write && !strobe_q;
    assign wr_cnt  = wr_go && addr == OFS_COUNT;
    assign wr_stat = wr_go && addr == OFS_STAT;
    assign evt     = pub_s ^ pub_d;

    assign flag_set[BIT_MATCH] = evt && (cnt_slow == match_q);
    assign flag_set[BIT_SEC]   = evt && tick_slow;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        ld_req  = 1'b0;
        unique case (state_q)
            LD_IDLE:    if (wr_cnt) state_d = LD_REQ;
            LD_REQ: begin
                ld_req = 1'b1;
                if (ld_ack_s) state_d = LD_RELEASE;
            end
            LD_RELEASE: if (!ld_ack_s) state_d = LD_IDLE;
            default:    state_d = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            pub_d    <= 1'b0;
            cnt_q    <= '0;
            match_q  <= '0;
            en_q     <= '0;
            flag_q   <= '0;
            ld_data  <= '0;
        end else begin
            strobe_q <= strobe;
            pub_d    <= pub_s;
            if (evt) cnt_q <= cnt_slow;
            if (wr_cnt && state_q == LD_IDLE) ld_data <= wdata[CNT_W-1:0];
            if (wr_go && addr == OFS_MATCH) match_q <= wdata[CNT_W-1:0];
            if (wr_go && addr == OFS_CTRL)  en_q    <= wdata[NUM_EVT-1:0];
            for (int i = 0; i < NUM_EVT; i++) begin
                if (flag_set[i])                 flag_q[i] <= 1'b1;
                else if (wr_stat && wdata[i])    flag_q[i] <= 1'b0;
            end
        end
    end

    assign irq   = |(flag_q & en_q);
    assign rd_oe = sel && strobe && !write;

    always_comb begin
        rdata = '0;
        if (rd_oe) begin
            unique case (addr)
                OFS_COUNT: rdata[CNT_W-1:0]   = cnt_q;
                OFS_MATCH: rdata[CNT_W-1:0]   = match_q;
                OFS_CTRL:  rdata[NUM_EVT-1:0] = en_q;
                OFS_STAT:  rdata[NUM_EVT-1:0] = flag_q;
                default:   rdata = '0;
            endcase
        end
    end

    // R5: request held until acknowledged, load data frozen during it
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !ld_ack_s) |=> ld_req);
    a_r5_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> $stable(ld_data));

    // R6: the match flag only rises after a counter update
    a_r6_match_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[BIT_MATCH]) |-> $past(evt));

    // R8: a write of one with no competing event clears the flag
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[BIT_SEC] && !evt) |=> !flag_q[BIT_SEC]);

    // R10: a counter write during a handshake leaves the load data alone
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && state_q != LD_IDLE) |=> $stable(ld_data));
endmodule

// File: rtl/rtc_pbus.sv
module rtc_pbus #(
    parameter int PRESC_W = 15,
    parameter int CNT_W   = 32
) (
    input  logic        bus_clk,
    input  logic        rst_n,
    input  logic        slow_clk,
    input  logic        pb_sel,
    input  logic        pb_strobe,
    input  logic        pb_write,
    input  logic [2:0]  pb_addr,
    input  logic [31:0] pb_wdata,
    output logic [31:0] pb_rdata,
    output logic        pb_rd_oe,
    output logic        rtc_irq
);
    logic             ld_req, ld_ack, ld_ack_s, pub_tog, pub_s, cnt_by_tick;
    logic [CNT_W-1:0] ld_data, cnt;

    rtc_slow_core #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_core (
        .slow_clk(slow_clk), .rst_n(rst_n),
        .ld_req(ld_req), .ld_data(ld_data), .ld_ack(ld_ack),
        .cnt(cnt), .cnt_by_tick(cnt_by_tick), .pub_tog(pub_tog)
    );

    rtc_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk(bus_clk), .rst_n(rst_n), .d(ld_ack), .q(ld_ack_s)
    );

    rtc_sync #(.W(1), .STAGES(2)) u_pub_sync (
        .clk(bus_clk), .rst_n(rst_n), .d(pub_tog), .q(pub_s)
    );

    rtc_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(bus_clk), .rst_n(rst_n),
        .sel(pb_sel), .strobe(pb_strobe), .write(pb_write),
        .addr(pb_addr), .wdata(pb_wdata),
        .rdata(pb_rdata), .rd_oe(pb_rd_oe), .irq(rtc_irq),
        .ld_req(ld_req), .ld_data(ld_data), .ld_ack_s(ld_ack_s),
        .pub_s(pub_s), .cnt_slow(cnt), .tick_slow(cnt_by_tick)
    );
endmodule

// File: tb/rtc_pbus_test.sv
module rtc_pbus_test;
    localparam int PW = 3;
    localparam int SEC_CYC = (1 << PW) * 8;

    logic        clk = 1'b0, slow = 1'b0, rst_n = 1'b0;
    logic        sel = 1'b0, strobe = 1'b0, write = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic        rd_oe, irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;
    always #80 slow = ~slow;

    rtc_pbus #(.PRESC_W(PW), .CNT_W(32)) uut (
        .bus_clk(clk), .rst_n(rst_n), .slow_clk(slow),
        .pb_sel(sel), .pb_strobe(strobe), .pb_write(write),
        .pb_addr(addr), .pb_wdata(wdata),
        .pb_rdata(rdata), .pb_rd_oe(rd_oe), .rtc_irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d, input logic s = 1'b1);
        @(negedge clk); sel = s; write = 1'b1; addr = a; wdata = d;
        @(negedge clk); strobe = 1'b1;
        @(negedge clk); strobe = 1'b0;
        @(negedge clk); sel = 1'b0; write = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; write = 1'b0; addr = a; strobe = 1'b1;
        #2 d = rdata;
        @(negedge clk); strobe = 1'b0; sel = 1'b0;
    endtask

    task automatic wait_count(input string req, input logic [31:0] target);
        logic [31:0] v;
        bit hit = 0;
        for (int i = 0; i < 400 && !hit; i++) begin
            bus_rd(3'd0, v);
            if (v == target) hit = 1;
        end
        check(req, {31'd0, hit}, 32'd1);
    endtask

    initial begin
        logic [31:0] v, c, st;
        int t_prev, changes;
        logic [31:0] loads [4];
        loads[0] = 32'h0000_0010; loads[1] = 32'h7FFF_FFFE;
        loads[2] = 32'hFFFF_FFFF; loads[3] = 32'hA5A5_0000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_rd(a[2:0], v);
            check("R1 reset register", v, 32'd0);
        end
        check("R1 irq low", {31'd0, irq}, 32'd0);

        // R3 no drive when idle or writing
        #2 check("R3 idle oe", {31'd0, rd_oe}, 32'd0);
        check("R3 idle rdata", rdata, 32'd0);
        @(negedge clk); sel = 1; write = 1; addr = 3'd1; wdata = 32'h1234;
        @(negedge clk); strobe = 1; #2;
        check("R3 write oe", {31'd0, rd_oe}, 32'd0);
        check("R3 write rdata", rdata, 32'd0);
        @(negedge clk); strobe = 0;
        @(negedge clk); sel = 0; write = 0;
        @(negedge clk); sel = 1; addr = 3'd1; strobe = 1; #2;
        check("R3 read oe", {31'd0, rd_oe}, 32'd1);
        check("R3 read data", rdata, 32'h1234);
        @(negedge clk); strobe = 0; sel = 0;

        // R2 interval and step, continuous read of offset 0
        @(negedge clk); sel = 1; write = 0; addr = 3'd0; strobe = 1;
        #2 c = rdata; t_prev = -1; changes = 0;
        for (int cyc = 0; cyc < 8 * SEC_CYC && changes < 5; cyc++) begin
            @(negedge clk); #2;
            if (rdata != c) begin
                check("R2 step of one", rdata, c + 1);
                if (t_prev >= 0) check("R2 interval", cyc - t_prev, SEC_CYC);
                t_prev = cyc; c = rdata; changes++;
            end
        end
        check("R2 saw ticks", changes, 5);
        @(negedge clk); strobe = 0; sel = 0;

        // R5 loads including wrap (R2)
        foreach (loads[k]) begin
            bus_wr(3'd0, loads[k]);
            wait_count("R5 load visible", loads[k]);
            wait_count("R5/R2 counts on", loads[k] + 1);
        end

        // R10 second write during handshake ignored
        bus_wr(3'd0, 32'h0000_0100);
        bus_wr(3'd0, 32'h0000_0900);
        wait_count("R10 first load kept", 32'h0000_0100);
        repeat (40) @(negedge clk);
        bus_rd(3'd0, v);
        check("R10 second write dropped", v[31:8], 24'h1);

        // R4 upper offsets and deselected write
        bus_wr(3'd1, 32'h0000_0777);
        bus_wr(3'd2, 32'd0);
        for (int a = 4; a < 8; a++) bus_wr(a[2:0], 32'hFFFF_FFFF);
        for (int a = 4; a < 8; a++) begin
            bus_rd(a[2:0], v);
            check("R4 unused offset reads zero", v, 32'd0);
        end
        bus_wr(3'd1, 32'h0000_0555, 1'b0);
        bus_rd(3'd1, v);
        check("R4 match untouched", v, 32'h0000_0777);
        bus_rd(3'd2, v);
        check("R4 ctrl untouched", v, 32'd0);

        // R7 load does not set second flag
        bus_rd(3'd0, c);
        wait_count("R7 fresh tick", c + 1);
        bus_wr(3'd3, 32'd3);
        bus_wr(3'd0, 32'h0000_0500);
        wait_count("R7 load seen", 32'h0000_0500);
        bus_rd(3'd3, st);
        check("R7 no flag from load", st, 32'd0);
        wait_count("R7 tick after load", 32'h0000_0501);
        repeat (4) @(negedge clk);
        bus_rd(3'd3, st);
        check("R7 flag from tick", st[1], 1'b1);

        // R6 match and R9 irq
        bus_wr(3'd2, 32'd1);
        bus_wr(3'd1, 32'h0000_0503);
        bus_rd(3'd3, st);
        check("R6 no early match", st[0], 1'b0);
        check("R9 irq low before match", {31'd0, irq}, 32'd0);
        wait_count("R6 reach match", 32'h0000_0503);
        repeat (4) @(negedge clk);
        bus_rd(3'd3, st);
        check("R6 match flag", st[0], 1'b1);
        check("R9 irq from match", {31'd0, irq}, 32'd1);

        // R8 write one clears bit 0, zero leaves bit 1
        bus_wr(3'd3, 32'd1);
        bus_rd(3'd3, st);
        check("R8 match cleared", st[0], 1'b0);
        check("R8 second flag kept", st[1], 1'b1);
        #2 check("R9 irq low after clear", {31'd0, irq}, 32'd0);

        // R9 enable sweep, expectation from status
        bus_wr(3'd1, 32'h0000_0505);
        wait_count("R9 set match again", 32'h0000_0505);
        repeat (4) @(negedge clk);
        for (int pass = 0; pass < 2; pass++) begin
            for (int en = 0; en < 4; en++) begin
                bus_wr(3'd2, en);
                bus_rd(3'd3, st);
                #1 check("R9 irq vs flags and enables", {31'd0, irq},
                         {31'd0, |(st[1:0] & en[1:0])});
            end
            bus_wr(3'd3, 32'd1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule